// File: doc/BRIEF.md
# Bypassable Fall-Through Sample FIFO

This block buffers up to sixteen 18-bit conversion results between a converter's conversion-complete write port and its output register. Each word holds 16 data bits plus two flag bits. A mode input selects the path. In buffered mode every conversion-complete event stores the new word. The oldest stored word is shown on the output without any read, and each rising edge of the read line moves the output on to the next-oldest word. In bypass mode the output follows the incoming conversion word and the buffer does nothing.

The read line and the conversion-complete strobe may arrive asynchronously. They pass through two-flop synchronizers and are edge-detected on the system clock. The mode input is synchronized in the same way. The conversion word must be stable while its strobe is being synchronized. A registered two-bit code gives the fill level. The buffer is emptied when bypass mode and a low read line are both present.

Top module: `sample_fifo`

## Requirements
- R1: While the synchronized mode is 0 (bypass), `data_o` equals `data_i`.
- R2: In bypass mode with the read line high, conversion-complete events store nothing and remove nothing. The level code stays unchanged. After a return to buffered mode, the stored words and their order are unchanged.
- R3: A write into an empty buffer puts that word on `data_o` without any read, and the level code becomes 00.
- R4: A write while 16 words are stored is dropped. The level code stays 11 and the output word is unchanged. The dropped word never appears on the output.
- R5: Each rising edge of the read line in buffered mode removes the head and presents the next-oldest word. After 15 edges on a full buffer, the 16th word written is on `data_o`.
- R6: A read edge when the buffer is empty leaves the last presented word on `data_o`. After a flush, that word is 0.
- R7: Synchronized mode 0 together with a synchronized read line of 0 empties the buffer, and the level code becomes 01.
- R8: The level code `stat_o` is 01 for 0 words, 00 for 1 to 7 words, 10 for 8 to 15 words and 11 for 16 words. It is registered, with a reset value of 01.
- R9: When a write and a read edge fall in the same clock, both are performed. The word count is unchanged, with two exceptions: an empty buffer only takes the write, and a full buffer only performs the read.
- R10: Holding the read line high does not cause further reads. Only a 0-to-1 transition counts as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 1 = buffered path, 0 = bypass (asynchronous) |
| rd_i | input | 1 | Read line; each rising edge advances the output word (asynchronous) |
| done_i | input | 1 | Conversion-complete strobe; its rising edge writes `data_i` (asynchronous) |
| data_i | input | 18 | Conversion word: 16 data bits and 2 flag bits |
| data_o | output | 18 | Head word in buffered mode, `data_i` in bypass mode |
| stat_o | output | 2 | Registered fill-level code |

## Verification
A write and a read edge can reach the storage in the same clock. The bench provokes this by raising the conversion strobe and the read line at the same falling clock edge, so that both pass through identical synchronizers and arrive together. It does this on an empty buffer, on a partly filled buffer and on a full buffer. The bench judges the result by the level code and the head word against a queue model: on an empty buffer only the write takes effect, in the middle the count is held, and on a full buffer only the read takes effect.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  parameter int unsigned WORD_W  = 18;
  parameter int unsigned N_SLOTS = 16;

  typedef enum logic [1:0] {
    LVL_LOW   = 2'b00,
    LVL_EMPTY = 2'b01,
    LVL_HIGH  = 2'b10,
    LVL_FULL  = 2'b11
  } lvl_e;
endpackage

// File: rtl/sfifo_sync.sv
module sfifo_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  output logic s_o
);
  logic m_q, s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= RST_VAL;
      s_q <= RST_VAL;
    end else begin
      m_q <= a_i;
      s_q <= m_q;
    end
  end

  assign s_o = s_q;
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int unsigned WORD_W  = 18,
  parameter int unsigned N_SLOTS = 16,
  localparam int unsigned PTR_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int unsigned CNT_W  = $clog2(N_SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] head_o,
  output logic [CNT_W-1:0]  cnt_d_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(N_SLOTS);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(N_SLOTS - 1);

  logic [WORD_W-1:0] mem_q [N_SLOTS];
  logic [WORD_W-1:0] last_q;
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_wr, do_rd;

  // full buffer drops the write even when a read frees a slot
  assign do_wr = wr_i && (cnt_q != FULL_CNT);
  assign do_rd = rd_i && (cnt_q != '0);

  always_comb begin
    if (flush_i) cnt_d = '0;
    else         cnt_d = cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (flush_i) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (do_wr) wp_q <= (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
      if (do_rd) begin
        rp_q   <= (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
        last_q <= mem_q[rp_q];
      end
    end
  end

  assign head_o  = (cnt_q != '0) ? mem_q[rp_q] : last_q;
  assign cnt_d_o = cnt_d;
endmodule

// File: rtl/sfifo_level.sv
module sfifo_level
  import sfifo_pkg::*;
#(
  parameter int unsigned N_SLOTS = 16,
  localparam int unsigned CNT_W  = $clog2(N_SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_d_i,
  output logic [1:0]       stat_o
);
  lvl_e lvl_d, lvl_q;

  always_comb begin
    if (cnt_d_i == '0)                          lvl_d = LVL_EMPTY;
    else if (cnt_d_i == CNT_W'(N_SLOTS))        lvl_d = LVL_FULL;
    else if (cnt_d_i >= CNT_W'(N_SLOTS / 2))    lvl_d = LVL_HIGH;
    else                                        lvl_d = LVL_LOW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= LVL_EMPTY;
    else         lvl_q <= lvl_d;
  end

  assign stat_o = lvl_q;
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo
  import sfifo_pkg::*;
#(
  parameter int unsigned WORD_W  = sfifo_pkg::WORD_W,
  parameter int unsigned N_SLOTS = sfifo_pkg::N_SLOTS,
  localparam int unsigned CNT_W  = $clog2(N_SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              rd_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic [1:0]        stat_o
);
  logic mode_s, rd_lvl, done_lvl;
  logic rd_prev_q, done_prev_q;
  logic rd_evt, wr_evt, flush;
  logic [WORD_W-1:0] head;
  logic [CNT_W-1:0]  cnt_d;

  sfifo_sync #(.RST_VAL(1'b0)) u_sync_mode (.clk_i, .rst_ni, .a_i(mode_i), .s_o(mode_s));
  // read line idles high; reset value avoids a false edge
  sfifo_sync #(.RST_VAL(1'b1)) u_sync_rd   (.clk_i, .rst_ni, .a_i(rd_i),   .s_o(rd_lvl));
  sfifo_sync #(.RST_VAL(1'b0)) u_sync_done (.clk_i, .rst_ni, .a_i(done_i), .s_o(done_lvl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_prev_q   <= 1'b1;
      done_prev_q <= 1'b0;
    end else begin
      rd_prev_q   <= rd_lvl;
      done_prev_q <= done_lvl;
    end
  end

  assign rd_evt = mode_s && rd_lvl && !rd_prev_q;
  assign wr_evt = mode_s && done_lvl && !done_prev_q;
  assign flush  = !mode_s && !rd_lvl;

  sfifo_store #(.WORD_W(WORD_W), .N_SLOTS(N_SLOTS)) u_store (
    .clk_i, .rst_ni,
    .flush_i(flush), .wr_i(wr_evt), .rd_i(rd_evt),
    .wdata_i(data_i), .head_o(head), .cnt_d_o(cnt_d)
  );

  sfifo_level #(.N_SLOTS(N_SLOTS)) u_level (
    .clk_i, .rst_ni, .cnt_d_i(cnt_d), .stat_o(stat_o)
  );

  assign data_o = mode_s ? head : data_i;
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int unsigned WORD_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_s,
  input logic              rd_lvl,
  input logic              rd_evt,
  input logic              wr_evt,
  input logic [WORD_W-1:0] data_i,
  input logic [WORD_W-1:0] data_o,
  input logic [1:0]        stat_o
);
  p_bypass_path_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_s |-> data_o == data_i);

  p_bypass_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_s && rd_lvl) |=> $stable(stat_o));

  p_first_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt && stat_o == 2'b01) |=> stat_o == 2'b00);

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt && !rd_evt && stat_o == 2'b11) |=> stat_o == 2'b11);

  p_empty_read_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_evt && !wr_evt && stat_o == 2'b01) |=> (!mode_s || $stable(data_o)));

  p_flush_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_s && !rd_lvl) |=> stat_o == 2'b01);

  p_full_both_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt && rd_evt && stat_o == 2'b11) |=> stat_o == 2'b10);
endmodule

bind sample_fifo sfifo_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_s(mode_s), .rd_lvl(rd_lvl),
  .rd_evt(rd_evt), .wr_evt(wr_evt), .data_i(data_i), .data_o(data_o),
  .stat_o(stat_o)
);

// File: tb/sample_fifo_bench.sv
module sample_fifo_bench;
  localparam int W = 18;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_i = 1'b1, rd_i = 1'b1, done_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] data_o;
  logic [1:0]   stat_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [W-1:0] q[$];
  logic [W-1:0] last_w = '0;
  logic m_mode = 1'b1;

  always #10 clk = ~clk;

  sample_fifo u_sample_fifo (.clk_i(clk), .rst_ni, .mode_i, .rd_i, .done_i,
                             .data_i, .data_o, .stat_o);

  function automatic logic [1:0] exp_stat();
    if (q.size() == 0) return 2'b01;
    if (q.size() == D) return 2'b11;
    if (q.size() >= D/2) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [W-1:0] exp_data();
    if (!m_mode) return data_i;
    return (q.size() != 0) ? q[0] : last_w;
  endfunction

  task automatic settle(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " data"}, data_o, exp_data());
    chk({req, " stat"}, {16'd0, stat_o}, {16'd0, exp_stat()});
  endtask

  task automatic do_write(logic [W-1:0] w);
    data_i = w; settle(1);
    done_i = 1'b1; settle(5);
    done_i = 1'b0; settle(4);
    if (m_mode && q.size() < D) q.push_back(w);
  endtask

  task automatic do_read();
    rd_i = 1'b0; settle(5);
    if (!m_mode) begin q.delete(); last_w = '0; end
    rd_i = 1'b1; settle(5);
    if (m_mode && q.size() != 0) last_w = q.pop_front();
  endtask

  task automatic do_both(logic [W-1:0] w);
    data_i = w; rd_i = 1'b0; settle(5);
    done_i = 1'b1; rd_i = 1'b1; settle(5);
    done_i = 1'b0; settle(4);
    if (q.size() == 0) q.push_back(w);
    else if (q.size() == D) last_w = q.pop_front();
    else begin last_w = q.pop_front(); q.push_back(w); end
  endtask

  task automatic set_mode(logic m);
    mode_i = m; settle(5); m_mode = m;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    settle(3); rst_ni = 1'b1; settle(6);
    chk_all("R8 reset");

    // R1 bypass path, R2 writes ignored
    set_mode(1'b0);
    for (int i = 0; i < 4; i++) begin
      data_i = 18'h1000 + 18'(i * 7); settle(1);
      chk("R1 bypass", data_o, data_i);
    end
    do_write(18'h2aaaa);
    chk_all("R2 bypass write");
    set_mode(1'b1);
    chk_all("R2 back to fifo");

    // R3 fall-through
    do_write(18'h30001);
    chk_all("R3 first word");
    for (int i = 2; i <= D; i++) begin
      do_write(18'h30000 + 18'(i));
      if (i == 7 || i == 8 || i == 15 || i == 16) chk_all("R8 level");
    end
    // R4 overflow
    do_write(18'h3ffff);
    chk_all("R4 overflow");
    do_write(18'h3fffe);
    chk_all("R4 overflow again");
    // R10 holding read high does not read
    settle(20);
    chk_all("R10 held high");
    // R5 read 15 edges
    for (int i = 0; i < D - 1; i++) begin
      do_read();
      chk_all("R5 advance");
    end
    chk("R5 sixteenth word", data_o, 18'h30010);
    do_read();
    chk_all("R6 drain");
    chk("R6 last word held", data_o, 18'h30010);
    do_read();
    chk_all("R6 read empty");

    // R9 same-cycle write and read
    do_both(18'h01234);
    chk_all("R9 both on empty");
    for (int i = 0; i < 5; i++) do_write(18'h05000 + 18'(i));
    do_both(18'h0abcd);
    chk_all("R9 both mid");
    while (q.size() < D) do_write(18'h06000 + 18'(q.size()));
    do_both(18'h0dead);
    chk_all("R9 both full");

    // R2 contents preserved across bypass
    set_mode(1'b0);
    do_write(18'h11111);
    set_mode(1'b1);
    chk_all("R2 preserved");
    do_read();
    chk_all("R2 order kept");

    // R7 flush
    set_mode(1'b0);
    do_read();
    chk_all("R7 flush bypass");
    set_mode(1'b1);
    chk_all("R7 flush empty");
    chk("R7 flushed word", data_o, 18'h0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int unsigned op = $urandom_range(0, 99);
      logic [W-1:0] w = 18'($urandom);
      if (op < 40) begin do_write(w); chk_all("R3 random write"); end
      else if (op < 75) begin do_read(); chk_all("R5 random read"); end
      else if (op < 88) begin do_both(w); chk_all("R9 random both"); end
      else if (op < 96) begin
        set_mode(1'b0); do_write(w); chk_all("R2 random bypass");
        set_mode(1'b1); chk_all("R2 random resume");
      end else begin
        set_mode(1'b0); do_read(); set_mode(1'b1); chk_all("R7 random flush");
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule